// File: doc/BRIEF.md
# Video-Mode Blanking Link-State Scheduler

This block is the timing engine of a display serial host running in video mode. It steps through every slot of a raster: one sync-start slot at the head of each line, then the horizontal sync-active, back-porch, active and front-porch periods. Vertically it runs through sync-active, back-porch, active and front-porch lines. All lengths come from programmed timing inputs. For every slot it tells a downstream packet builder what to place on the data lanes. The choices are a sync-start packet, a zero-filled blanking packet, pixel payload, or nothing at all, which means the data lanes sit in low power.

Each of the three horizontal porches in active lines has its own selection bit, and so does the whole vertical blanking. A set bit fills the period with high-speed blanking packets. A clear bit lets the lanes drop to low power. No matter what the bits say, the first vertical sync-active line always falls to low power after its sync-start, so low power is reached at least once per frame. The block makes no check that a porch is long enough for the lanes to round-trip through low power.

A separate always-on bit controls the clock lane. When that bit is clear, the clock lane is stopped only inside a run of low-power data slots. It is stopped one slot after the data lanes have settled and restarted one slot before they leave.

Top module: `vm_link_scheduler`

## Requirements
- R1: While reset is held, `slot_cmd` is 0 (low-power idle), `data_lp` is 1 and `clk_lane_en` is 1.
- R2: A line is 1 + h_sa + h_bp + h_act + h_fp slots long, in this order: sync-start slot, sync-active, back porch, active, front porch. After reset the first slot output is the sync-start of the first sync-active line.
- R3: The first slot of every line carries `slot_cmd` = 1 (sync-start packet), in both active and blanking lines and whatever the selection bits are.
- R4: In active lines, every non-sync slot of the sync-active, back-porch and front-porch periods carries 2 (zero-filled blanking packet) when that period's own selection bit (`hsa_blank`, `hbp_blank`, `hfp_blank`) is 1, and 0 (low power) when it is 0.
- R5: A frame is v_sa + v_bp + v_act + v_fp lines in the order sync-active, back porch, active, front porch. In every blanking line except the first one, non-sync slots carry 2 when `vblank_blank` is 1 and 0 when it is 0.
- R6: In the first sync-active line of each frame, every non-sync slot carries 0, even when `vblank_blank` is 1.
- R7: Slots of the active period within active lines carry 3 (pixel payload).
- R8: `data_lp` is 1 exactly in the slots whose `slot_cmd` is 0.
- R9: With `clk_always_on` at 1, `clk_lane_en` stays 1 in every slot.
- R10: With `clk_always_on` at 0, `clk_lane_en` is 0 in a slot only when the data lanes are in low power in that slot, in the slot before it and in the slot after it. In every other slot it is 1.
- R11: A period of one slot is honoured in any mode. It is not lengthened or merged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_sa | input | HW | Horizontal sync-active length in slots (at least 1) |
| h_bp | input | HW | Horizontal back-porch length in slots (at least 1) |
| h_act | input | HW | Active payload length in slots (at least 1) |
| h_fp | input | HW | Horizontal front-porch length in slots (at least 1) |
| v_sa | input | VW | Vertical sync-active lines (at least 1) |
| v_bp | input | VW | Vertical back-porch lines (at least 1) |
| v_act | input | VW | Active lines (at least 1) |
| v_fp | input | VW | Vertical front-porch lines (at least 1) |
| hsa_blank | input | 1 | 1: blanking packets in sync-active; 0: low power |
| hbp_blank | input | 1 | 1: blanking packets in back porch; 0: low power |
| hfp_blank | input | 1 | 1: blanking packets in front porch; 0: low power |
| vblank_blank | input | 1 | 1: blanking packets in vertical blanking; 0: low power |
| clk_always_on | input | 1 | 1: clock lane never gated |
| slot_cmd | output | 2 | 0 idle, 1 sync-start, 2 blanking packet, 3 pixel payload |
| data_lp | output | 1 | Data lanes requested in low power |
| clk_lane_en | output | 1 | Clock lane requested running |

## Verification
Two things can land in the same cycle here. The first pair is the clock-lane restart and the last low-power slot before a sync-start. With a low-power front porch and the always-on bit clear, the clock must rise in that final idle slot, while the data lanes are still idle. The second pair is the forced low-power entry of the first sync-active line and a vertical selection bit asking for blanking packets. Here the forced entry must win. The bench sweeps all 32 combinations of the five mode bits over two small rasters, one of which has one-slot periods. It compares every output slot of two frames against an arithmetic model of slot position, line and lookahead idle state.

// File: rtl/vm_sched_pkg.sv
package vm_sched_pkg;
  typedef enum logic [1:0] {
    SLOT_LP    = 2'd0,
    SLOT_SYNC  = 2'd1,
    SLOT_BLANK = 2'd2,
    SLOT_PIXEL = 2'd3
  } slot_e;

  typedef enum logic [2:0] {
    HP_SYNC  = 3'd0,
    HP_SACT  = 3'd1,
    HP_BACK  = 3'd2,
    HP_ACT   = 3'd3,
    HP_FRONT = 3'd4
  } hphase_e;

  typedef enum logic [1:0] {
    VP_SACT  = 2'd0,
    VP_BACK  = 2'd1,
    VP_ACT   = 2'd2,
    VP_FRONT = 2'd3
  } vphase_e;
endpackage

// File: rtl/vm_raster_counter.sv
module vm_raster_counter
  import vm_sched_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] h_sa,
  input  logic [HW-1:0] h_bp,
  input  logic [HW-1:0] h_act,
  input  logic [HW-1:0] h_fp,
  input  logic [VW-1:0] v_sa,
  input  logic [VW-1:0] v_bp,
  input  logic [VW-1:0] v_act,
  input  logic [VW-1:0] v_fp,
  output hphase_e       hph,
  output vphase_e       vph,
  output logic          first_line
);
  localparam logic [HW-1:0] H_ONE = HW'(1);
  localparam logic [VW-1:0] V_ONE = VW'(1);

  hphase_e       hph_q, hph_d;
  vphase_e       vph_q, vph_d;
  logic [HW-1:0] hcnt_q, hcnt_d;
  logic [VW-1:0] vcnt_q, vcnt_d;
  logic          line_end;

  // next-state: horizontal phase walk, vertical advance on line end
  always_comb begin
    hph_d    = hph_q;
    hcnt_d   = hcnt_q + H_ONE;
    vph_d    = vph_q;
    vcnt_d   = vcnt_q;
    line_end = 1'b0;
    case (hph_q)
      HP_SYNC:  begin hph_d = HP_SACT; hcnt_d = '0; end
      HP_SACT:  if (hcnt_q == h_sa - H_ONE)  begin hph_d = HP_BACK;  hcnt_d = '0; end
      HP_BACK:  if (hcnt_q == h_bp - H_ONE)  begin hph_d = HP_ACT;   hcnt_d = '0; end
      HP_ACT:   if (hcnt_q == h_act - H_ONE) begin hph_d = HP_FRONT; hcnt_d = '0; end
      HP_FRONT: if (hcnt_q == h_fp - H_ONE) begin
        hph_d    = HP_SYNC;
        hcnt_d   = '0;
        line_end = 1'b1;
      end
      default:  begin hph_d = HP_SYNC; hcnt_d = '0; end
    endcase
    if (line_end) begin
      vcnt_d = vcnt_q + V_ONE;
      case (vph_q)
        VP_SACT:  if (vcnt_q == v_sa - V_ONE)  begin vph_d = VP_BACK;  vcnt_d = '0; end
        VP_BACK:  if (vcnt_q == v_bp - V_ONE)  begin vph_d = VP_ACT;   vcnt_d = '0; end
        VP_ACT:   if (vcnt_q == v_act - V_ONE) begin vph_d = VP_FRONT; vcnt_d = '0; end
        VP_FRONT: if (vcnt_q == v_fp - V_ONE)  begin vph_d = VP_SACT;  vcnt_d = '0; end
        default:  begin vph_d = VP_SACT; vcnt_d = '0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hph_q  <= HP_SYNC;
      hcnt_q <= '0;
      vph_q  <= VP_SACT;
      vcnt_q <= '0;
    end else begin
      hph_q  <= hph_d;
      hcnt_q <= hcnt_d;
      vph_q  <= vph_d;
      vcnt_q <= vcnt_d;
    end
  end

  assign hph        = hph_q;
  assign vph        = vph_q;
  assign first_line = (vph_q == VP_SACT) && (vcnt_q == '0);

  // a sync-start slot lasts exactly one slot and opens the sync-active period
  assert_sync_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hph_q == HP_SYNC) |=> (hph_q == HP_SACT));

  // the vertical phase only moves at a line boundary
  assert_vph_at_line_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hph_q != HP_FRONT) |=> $stable(vph_q));

  // every line opens with a sync-start slot after the front porch
  assert_line_opens_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hph_q == HP_FRONT && $past(hph_q) == HP_FRONT && hph_d != HP_FRONT) |=> (hph_q == HP_SYNC));
endmodule

// File: rtl/vm_slot_classifier.sv
module vm_slot_classifier
  import vm_sched_pkg::*;
(
  input  hphase_e hph,
  input  vphase_e vph,
  input  logic    first_line,
  input  logic    hsa_blank,
  input  logic    hbp_blank,
  input  logic    hfp_blank,
  input  logic    vblank_blank,
  output slot_e   cmd
);
  always_comb begin
    cmd = SLOT_LP;
    if (hph == HP_SYNC) begin
      cmd = SLOT_SYNC;
    end else if (vph != VP_ACT) begin
      // first sync-active line forces low power once per frame
      if (!first_line && vblank_blank) cmd = SLOT_BLANK;
    end else begin
      case (hph)
        HP_SACT:  if (hsa_blank) cmd = SLOT_BLANK;
        HP_BACK:  if (hbp_blank) cmd = SLOT_BLANK;
        HP_ACT:   cmd = SLOT_PIXEL;
        HP_FRONT: if (hfp_blank) cmd = SLOT_BLANK;
        default:  cmd = SLOT_LP;
      endcase
    end
  end
endmodule

// File: rtl/vm_lane_ctrl.sv
module vm_lane_ctrl
  import vm_sched_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  slot_e cmd_next,
  input  logic  clk_always_on,
  output slot_e slot_cmd,
  output logic  data_lp,
  output logic  clk_lane_en
);
  slot_e cmd_q;
  logic  lp_prev_q;
  logic  lp_now, lp_next;

  assign lp_now  = (cmd_q == SLOT_LP);
  assign lp_next = (cmd_next == SLOT_LP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= SLOT_LP;
      lp_prev_q <= 1'b1;
    end else begin
      cmd_q     <= cmd_next;
      lp_prev_q <= lp_now;
    end
  end

  // gate only deep inside an idle run: one settled slot behind, one ahead
  assign clk_lane_en = clk_always_on | ~lp_next | ~lp_now | ~lp_prev_q;
  assign slot_cmd    = cmd_q;
  assign data_lp     = lp_now;

  assert_aon_runs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clk_always_on |-> clk_lane_en);

  // clock stops only after the data lanes have already settled in low power
  assert_gate_after_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_lane_en) |-> (data_lp && $past(data_lp)));

  // data lanes leave low power only with the clock already running
  assert_restart_before_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_lp && $past(data_lp)) |-> $past(clk_lane_en));
endmodule

// File: rtl/vm_link_scheduler.sv
module vm_link_scheduler
  import vm_sched_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] h_sa,
  input  logic [HW-1:0] h_bp,
  input  logic [HW-1:0] h_act,
  input  logic [HW-1:0] h_fp,
  input  logic [VW-1:0] v_sa,
  input  logic [VW-1:0] v_bp,
  input  logic [VW-1:0] v_act,
  input  logic [VW-1:0] v_fp,
  input  logic          hsa_blank,
  input  logic          hbp_blank,
  input  logic          hfp_blank,
  input  logic          vblank_blank,
  input  logic          clk_always_on,
  output logic [1:0]    slot_cmd,
  output logic          data_lp,
  output logic          clk_lane_en
);
  localparam int RSYNC_DEPTH = 2;

  logic [RSYNC_DEPTH-1:0] rsync_q;
  logic    rst_int_n;
  hphase_e hph;
  vphase_e vph;
  logic    first_line;
  slot_e   cmd_next;
  slot_e   cmd_out;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[RSYNC_DEPTH-2:0], 1'b1};
  end
  assign rst_int_n = rsync_q[RSYNC_DEPTH-1];

  vm_raster_counter #(.HW(HW), .VW(VW)) u_raster (
    .clk(clk), .rst_n(rst_int_n),
    .h_sa(h_sa), .h_bp(h_bp), .h_act(h_act), .h_fp(h_fp),
    .v_sa(v_sa), .v_bp(v_bp), .v_act(v_act), .v_fp(v_fp),
    .hph(hph), .vph(vph), .first_line(first_line)
  );

  vm_slot_classifier u_class (
    .hph(hph), .vph(vph), .first_line(first_line),
    .hsa_blank(hsa_blank), .hbp_blank(hbp_blank), .hfp_blank(hfp_blank),
    .vblank_blank(vblank_blank), .cmd(cmd_next)
  );

  vm_lane_ctrl u_lane (
    .clk(clk), .rst_n(rst_int_n), .cmd_next(cmd_next),
    .clk_always_on(clk_always_on), .slot_cmd(cmd_out),
    .data_lp(data_lp), .clk_lane_en(clk_lane_en)
  );

  assign slot_cmd = cmd_out;

  // pixel payload only ever follows a slot of an active line
  assert_pixel_in_active_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_out == SLOT_PIXEL) |-> ($past(vph) == VP_ACT));

  // idle indication and command code agree at the port
  assert_lp_vs_code_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    data_lp |-> (slot_cmd == 2'd0));
endmodule

// File: tb/test_vm_link_scheduler.sv
module test_vm_link_scheduler;
  logic        clk;
  logic        rst_n;
  logic [11:0] h_sa, h_bp, h_act, h_fp;
  logic [11:0] v_sa, v_bp, v_act, v_fp;
  logic        hsa_blank, hbp_blank, hfp_blank, vblank_blank, clk_always_on;
  logic [1:0]  slot_cmd;
  logic        data_lp, clk_lane_en;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  vm_link_scheduler i_vm_link_scheduler (
    .clk(clk), .rst_n(rst_n),
    .h_sa(h_sa), .h_bp(h_bp), .h_act(h_act), .h_fp(h_fp),
    .v_sa(v_sa), .v_bp(v_bp), .v_act(v_act), .v_fp(v_fp),
    .hsa_blank(hsa_blank), .hbp_blank(hbp_blank), .hfp_blank(hfp_blank),
    .vblank_blank(vblank_blank), .clk_always_on(clk_always_on),
    .slot_cmd(slot_cmd), .data_lp(data_lp), .clk_lane_en(clk_lane_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // bench-side copy of the programmed raster
  int c_hsa, c_hbp, c_hact, c_hfp, c_vsa, c_vbp, c_vact, c_vfp;
  int m_hsa, m_hbp, m_hfp, m_vb, m_aon;

  function automatic int line_len();
    return 1 + c_hsa + c_hbp + c_hact + c_hfp;
  endfunction

  function automatic int frame_lines();
    return c_vsa + c_vbp + c_vact + c_vfp;
  endfunction

  // expected code of output slot k counted from the first slot after reset
  function automatic int exp_cmd(int k);
    int pos, line, p;
    if (k < 0) return 0;
    pos  = k % line_len();
    line = (k / line_len()) % frame_lines();
    if (pos == 0) return 1;
    if (line < c_vsa + c_vbp || line >= c_vsa + c_vbp + c_vact) begin
      if (line == 0) return 0;
      return (m_vb != 0) ? 2 : 0;
    end
    p = pos - 1;
    if (p < c_hsa) return (m_hsa != 0) ? 2 : 0;
    p -= c_hsa;
    if (p < c_hbp) return (m_hbp != 0) ? 2 : 0;
    p -= c_hbp;
    if (p < c_hact) return 3;
    return (m_hfp != 0) ? 2 : 0;
  endfunction

  function automatic string tag_of(int k);
    int pos, line, p;
    pos  = k % line_len();
    line = (k / line_len()) % frame_lines();
    if (pos == 0) return "R3 R2";
    if (line == 0) return "R6";
    if (line < c_vsa + c_vbp || line >= c_vsa + c_vbp + c_vact) return "R5";
    p = pos - 1 - c_hsa - c_hbp;
    if (p >= 0 && p < c_hact) return "R7 R2";
    return "R4 R11";
  endfunction

  task automatic chk(string req, int act, int exp, int k);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s slot=%0d actual=%0d expected=%0d", req, k, act, exp);
    end
  endtask

  task automatic run_case(int modes);
    int n;
    m_hsa = modes & 1;
    m_hbp = (modes >> 1) & 1;
    m_hfp = (modes >> 2) & 1;
    m_vb  = (modes >> 3) & 1;
    m_aon = (modes >> 4) & 1;
    @(negedge clk);
    rst_n = 1'b0;
    h_sa = 12'(c_hsa); h_bp = 12'(c_hbp); h_act = 12'(c_hact); h_fp = 12'(c_hfp);
    v_sa = 12'(c_vsa); v_bp = 12'(c_vbp); v_act = 12'(c_vact); v_fp = 12'(c_vfp);
    hsa_blank = m_hsa[0]; hbp_blank = m_hbp[0]; hfp_blank = m_hfp[0];
    vblank_blank = m_vb[0]; clk_always_on = m_aon[0];
    repeat (2) begin
      @(negedge clk);
      chk("R1 cmd", int'(slot_cmd), 0, -1);
      chk("R1 lp", int'(data_lp), 1, -1);
      chk("R1 clk", int'(clk_lane_en), 1, -1);
    end
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    n = 2 * line_len() * frame_lines();
    for (int k = 0; k < n; k++) begin
      int e, elp, eclk;
      @(posedge clk);
      @(negedge clk);
      e    = exp_cmd(k);
      elp  = (e == 0) ? 1 : 0;
      eclk = (m_aon != 0 || exp_cmd(k + 1) != 0 || e != 0 || exp_cmd(k - 1) != 0) ? 1 : 0;
      chk(tag_of(k), int'(slot_cmd), e, k);
      chk("R8", int'(data_lp), elp, k);
      chk((m_aon != 0) ? "R9" : "R10", int'(clk_lane_en), eclk, k);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    for (int cfg = 0; cfg < 2; cfg++) begin
      if (cfg == 0) begin
        c_hsa = 2; c_hbp = 2; c_hact = 3; c_hfp = 2;
        c_vsa = 2; c_vbp = 1; c_vact = 2; c_vfp = 1;
      end else begin
        c_hsa = 1; c_hbp = 1; c_hact = 3; c_hfp = 1;   // one-slot periods, R11
        c_vsa = 3; c_vbp = 2; c_vact = 1; c_vfp = 2;
      end
      for (int m = 0; m < 32; m++) run_case(m);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        total++;
        bad++;
        $display("FAIL watchdog all requirements actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end
endmodule